// File: doc/BRIEF.md
# Setup/Hold Violation Trigger

This block watches two oversampled lines, a sampled clock line and a sampled data line, both taken at a fast reference rate. It raises a one-cycle trigger strobe whenever a data transition lands too close to a chosen clock transition. "Too close" means either within a programmable number of reference samples before the clock transition (setup) or within a programmable number of samples after it (hold). Timing is resolved to one reference sample; nothing finer is attempted.

Which clock transition defines the window is selectable: rising or falling. Which data transitions count is also selectable: rising only, falling only, either, or none. An optional qualifier input can gate the strobe so that a violation is reported only while that input sits at a programmed level. Each clock transition yields at most one strobe, however many violating data transitions surround it.

All three lines pass through a register chain of `SYNC_DEPTH` stages before any edge is detected. The strobe is registered, so a violation appears on `trig_o` `SYNC_DEPTH + 1` reference cycles after the deciding sample was presented. That is two cycles at the default depth of one.

Top module: `sht_trigger`

## Requirements
- R1: While `rst_n` is low `trig_o` is 0. The first line samples after reset are never taken as transitions, whatever level the lines hold while reset is released.
- R2: Let the selected clock transition be presented at reference sample c, and a counted data transition at sample c-d with 1 <= d <= `setup_len_i`. Then `trig_o` is 1 for one cycle, `SYNC_DEPTH+1` cycles after sample c. With d > `setup_len_i` no strobe results.
- R3: A counted data transition at sample c+d with 1 <= d <= `hold_len_i` gives a one-cycle strobe `SYNC_DEPTH+1` cycles after sample c+d. With d > `hold_len_i` no strobe results.
- R4: A counted data transition presented in the same sample as the selected clock transition is always a violation, even with `setup_len_i` = `hold_len_i` = 0.
- R5: With `clk_fall_i` = 0 the window is opened by 0-to-1 transitions of `line_clk_i`. With `clk_fall_i` = 1 it is opened by 1-to-0 transitions. The other direction opens no window.
- R6: `dat_mode_i` selects the counted data transitions: 2'b00 none, 2'b01 rising only, 2'b10 falling only, 2'b11 both. Data transitions that are not counted produce no strobe.
- R7: With `qual_en_i` = 1 a violation produces a strobe only if the sampled `qual_i` equals `qual_lvl_i`. With `qual_en_i` = 0, `qual_i` has no effect.
- R8: At most one strobe is produced per selected clock transition. A setup violation followed by a hold violation on the same clock transition gives a single strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_clk_i | input | 1 | Sampled level of the observed clock line |
| line_dat_i | input | 1 | Sampled level of the observed data line |
| qual_i | input | 1 | Sampled level of the logic qualifier line |
| clk_fall_i | input | 1 | 0: rising clock transitions open the window, 1: falling |
| dat_mode_i | input | 2 | Counted data transitions: 00 none, 01 rise, 10 fall, 11 both |
| setup_len_i | input | CW | Setup window length in reference samples |
| hold_len_i | input | CW | Hold window length in reference samples |
| qual_en_i | input | 1 | Enables gating by the qualifier |
| qual_lvl_i | input | 1 | Qualifier level required for a strobe |
| trig_o | output | 1 | One-cycle violation strobe |

## Verification
The bench places a single data transition at offsets just inside and just outside both window edges. A design with an off-by-one in the setup compare or in the hold countdown would miss a boundary strobe or add one past the boundary. A zero-length window with a coincident data transition checks the coincidence rule, which a design that only counted strict before/after distances would drop. Both lines are held high across reset release; a design that treats its reset register value as a real sample would report a phantom coincident violation there. Paired data transitions straddling one clock transition expose a design that strobes once for setup and again for hold, and wrong-polarity clock or data transitions expose a design that ignores the polarity selects.

// File: rtl/sht_pkg.sv
package sht_pkg;

   // encoding of the counted data transitions
   typedef enum logic [1:0] {
      DM_NONE = 2'b00,
      DM_RISE = 2'b01,
      DM_FALL = 2'b10,
      DM_BOTH = 2'b11
   } dmode_e;

   // true when the step from prev to cur is a transition the mode counts
   function automatic logic step_counts(input logic prev, input logic cur, input dmode_e m);
      logic up, dn;
      up = ~prev & cur;
      dn = prev & ~cur;
      unique case (m)
         DM_RISE: return up;
         DM_FALL: return dn;
         DM_BOTH: return up | dn;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/sht_sampler.sv
module sht_sampler #(
   parameter int W     = 3,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] cur,
   output logic [W-1:0] prev,
   output logic         primed
);

   logic [DEPTH:0] vld_q;

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] stg_q;
         always_ff @(posedge clk) begin
            if (!rst_n) stg_q <= '0;
            else        stg_q <= din;
         end
         assign cur = stg_q;
      end else begin : g_chain
         logic [W-1:0] stg_q [DEPTH];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
            end else begin
               stg_q[0] <= din;
               for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
            end
         end
         assign cur = stg_q[DEPTH-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev  <= '0;
         vld_q <= '0;
      end else begin
         prev  <= cur;
         vld_q <= {vld_q[DEPTH-1:0], 1'b1};
      end
   end

   // both cur and prev hold real samples once the marker reaches the end
   assign primed = vld_q[DEPTH];

endmodule

// File: rtl/sht_setup_tracker.sv
module sht_setup_tracker #(
   parameter int CW = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        dat_edge,
   input  logic        clk_edge,
   input  logic [CW-1:0] setup_len,
   output logic [CW:0] since_q,
   output logic        setup_hit
);

   localparam logic [CW:0] SAT = '1;

   // one extra bit so the saturated value exceeds any setup length
   always_ff @(posedge clk) begin
      if (!rst_n)              since_q <= SAT;
      else if (dat_edge)       since_q <= {{CW{1'b0}}, 1'b1};
      else if (since_q != SAT) since_q <= since_q + 1'b1;
   end

   // coincident data transition or one within the setup distance
   assign setup_hit = clk_edge & (dat_edge | (since_q <= {1'b0, setup_len}));

endmodule

// File: rtl/sht_hold_window.sv
module sht_hold_window #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clk_edge,
   input  logic          dat_edge,
   input  logic [CW-1:0] hold_len,
   output logic [CW-1:0] hold_q,
   output logic          hold_hit
);

   always_ff @(posedge clk) begin
      if (!rst_n)           hold_q <= '0;
      else if (clk_edge)    hold_q <= hold_len;
      else if (hold_q != 0) hold_q <= hold_q - 1'b1;
   end

   assign hold_hit = dat_edge & (hold_q != '0);

endmodule

// File: rtl/sht_trigger.sv
module sht_trigger
   import sht_pkg::*;
#(
   parameter int CW         = 8,
   parameter int SYNC_DEPTH = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_clk_i,
   input  logic          line_dat_i,
   input  logic          qual_i,
   input  logic          clk_fall_i,
   input  logic [1:0]    dat_mode_i,
   input  logic [CW-1:0] setup_len_i,
   input  logic [CW-1:0] hold_len_i,
   input  logic          qual_en_i,
   input  logic          qual_lvl_i,
   output logic          trig_o
);

   localparam int LANES  = 3;
   localparam int L_CLK  = 0;
   localparam int L_DAT  = 1;
   localparam int L_QUAL = 2;

   generate
      if (CW < 1)         begin : g_bad_cw   $error("sht_trigger: CW must be at least 1"); end
      if (SYNC_DEPTH < 1) begin : g_bad_sync $error("sht_trigger: SYNC_DEPTH must be at least 1"); end
   endgenerate

   logic [LANES-1:0] cur, prev;
   logic             primed;
   logic             clk_edge, dat_edge, qual_ok;
   logic [CW:0]      since_q;
   logic [CW-1:0]    hold_q;
   logic             setup_hit, hold_hit;
   logic             fire, fired_q;

   sht_sampler #(.W(LANES), .DEPTH(SYNC_DEPTH)) u_smp (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    ({qual_i, line_dat_i, line_clk_i}),
      .cur    (cur),
      .prev   (prev),
      .primed (primed)
   );

   always_comb begin
      clk_edge = primed & (clk_fall_i ? (prev[L_CLK] & ~cur[L_CLK])
                                      : (~prev[L_CLK] & cur[L_CLK]));
      dat_edge = primed & step_counts(prev[L_DAT], cur[L_DAT], dmode_e'(dat_mode_i));
      qual_ok  = ~qual_en_i | (cur[L_QUAL] == qual_lvl_i);
   end

   sht_setup_tracker #(.CW(CW)) u_setup (
      .clk       (clk),
      .rst_n     (rst_n),
      .dat_edge  (dat_edge),
      .clk_edge  (clk_edge),
      .setup_len (setup_len_i),
      .since_q   (since_q),
      .setup_hit (setup_hit)
   );

   sht_hold_window #(.CW(CW)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_edge (clk_edge),
      .dat_edge (dat_edge),
      .hold_len (hold_len_i),
      .hold_q   (hold_q),
      .hold_hit (hold_hit)
   );

   // a clock transition starts a fresh report slot; hold hits use the slot once
   always_comb begin
      if (clk_edge) fire = qual_ok & setup_hit;
      else          fire = qual_ok & hold_hit & ~fired_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fired_q <= 1'b0;
         trig_o  <= 1'b0;
      end else begin
         fired_q <= clk_edge ? fire : (fired_q | fire);
         trig_o  <= fire;
      end
   end

endmodule

// File: rtl/sht_trigger_chk.sv
module sht_trigger_chk #(
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clk_edge,
   input logic          dat_edge,
   input logic          qual_ok,
   input logic          fired_q,
   input logic [CW:0]   since_q,
   input logic [CW-1:0] hold_q,
   input logic [CW-1:0] hold_len_i,
   input logic          trig_o
);

   // R3
   hold_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_edge |=> (hold_q == $past(hold_len_i)));

   // R2
   setup_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_edge |=> (since_q == {{CW{1'b0}}, 1'b1}));

   // R4
   coincident_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_edge && dat_edge && qual_ok) |=> trig_o);

   // R7
   qual_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !qual_ok |=> !trig_o);

   // R8
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fired_q && !clk_edge) |=> !trig_o);

   // R1
   quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_edge && !dat_edge) |=> !trig_o);

endmodule

bind sht_trigger sht_trigger_chk #(.CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clk_edge   (clk_edge),
   .dat_edge   (dat_edge),
   .qual_ok    (qual_ok),
   .fired_q    (fired_q),
   .since_q    (since_q),
   .hold_q     (hold_q),
   .hold_len_i (hold_len_i),
   .trig_o     (trig_o)
);

// File: tb/tb_sht_trigger.sv
module tb_sht_trigger;

   localparam int CW   = 8;
   localparam int NONE = 99;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line_clk_i = 1'b0;
   logic          line_dat_i = 1'b0;
   logic          qual_i = 1'b0;
   logic          clk_fall_i = 1'b0;
   logic [1:0]    dat_mode_i = 2'b01;
   logic [CW-1:0] setup_len_i = '0;
   logic [CW-1:0] hold_len_i = '0;
   logic          qual_en_i = 1'b0;
   logic          qual_lvl_i = 1'b0;
   logic          trig_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int trig_cnt = 0;
   int first_trig = -1;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   sht_trigger #(.CW(CW), .SYNC_DEPTH(1)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_clk_i  (line_clk_i),
      .line_dat_i  (line_dat_i),
      .qual_i      (qual_i),
      .clk_fall_i  (clk_fall_i),
      .dat_mode_i  (dat_mode_i),
      .setup_len_i (setup_len_i),
      .hold_len_i  (hold_len_i),
      .qual_en_i   (qual_en_i),
      .qual_lvl_i  (qual_lvl_i),
      .trig_o      (trig_o)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && trig_o) begin
         if (trig_cnt == 0) first_trig = cyc;
         trig_cnt = trig_cnt + 1;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // one clock transition at step 0, data transition(s) at off and off2
   task automatic run_case(input string req, input string name,
                           input bit cpol, input bit crise, input logic [1:0] mode,
                           input bit drise, input int su, input int ho,
                           input int off, input int off2,
                           input bit qen, input bit qlvl, input bit qval,
                           input int exp);
      int clk_cyc, dat_cyc, want;
      clk_cyc = 0;
      dat_cyc = 0;
      @(negedge clk); line_clk_i = ~crise;
      idle(20);
      @(negedge clk); line_dat_i = ~drise;
      idle(20);
      clk_fall_i  = cpol;
      dat_mode_i  = mode;
      setup_len_i = CW'(su);
      hold_len_i  = CW'(ho);
      qual_en_i   = qen;
      qual_lvl_i  = qlvl;
      qual_i      = qval;
      idle(3);
      trig_cnt   = 0;
      first_trig = -1;
      for (int t = -15; t <= 15; t++) begin
         @(negedge clk);
         if (t == 0) begin line_clk_i = crise; clk_cyc = cyc; end
         if (t == off) begin line_dat_i = ~line_dat_i; dat_cyc = cyc; end
         if (t == off2) line_dat_i = ~line_dat_i;
      end
      idle(20);
      check(req, {name, " strobe count"}, trig_cnt, exp);
      if (exp == 1 && off2 == NONE) begin
         want = ((off > 0) ? dat_cyc : clk_cyc) + 2;
         check(req, {name, " strobe cycle"}, first_trig, want);
      end
   endtask

   task automatic t_reset();
      // R1: lines high through reset release; coincident zero window would fire
      line_clk_i = 1'b1; line_dat_i = 1'b1;
      dat_mode_i = 2'b11; clk_fall_i = 1'b0;
      setup_len_i = '0; hold_len_i = '0;
      rst_n = 1'b0;
      idle(4);
      check("R1", "trig_o in reset", int'(trig_o), 0);
      trig_cnt = 0;
      @(negedge clk); rst_n = 1'b1;
      idle(10);
      check("R1", "no phantom strobe after release", trig_cnt, 0);
   endtask

   task automatic t_setup();
      run_case("R2", "setup at limit",   0, 1, 2'b01, 1, 4, 3, -4, NONE, 0, 0, 0, 1);
      run_case("R2", "setup beyond",     0, 1, 2'b01, 1, 4, 3, -5, NONE, 0, 0, 0, 0);
      run_case("R2", "setup deep",       0, 1, 2'b01, 1, 4, 3, -1, NONE, 0, 0, 0, 1);
   endtask

   task automatic t_hold();
      run_case("R3", "hold at limit",    0, 1, 2'b01, 1, 4, 3, 3, NONE, 0, 0, 0, 1);
      run_case("R3", "hold beyond",      0, 1, 2'b01, 1, 4, 3, 4, NONE, 0, 0, 0, 0);
   endtask

   task automatic t_coincident();
      run_case("R4", "zero window same sample", 0, 1, 2'b01, 1, 0, 0, 0, NONE, 0, 0, 0, 1);
      run_case("R4", "zero window one before",  0, 1, 2'b01, 1, 0, 0, -1, NONE, 0, 0, 0, 0);
      run_case("R4", "zero window one after",   0, 1, 2'b01, 1, 0, 0, 1, NONE, 0, 0, 0, 0);
   endtask

   task automatic t_clk_pol();
      run_case("R5", "falling clock selected",  1, 0, 2'b01, 1, 4, 3, -2, NONE, 0, 0, 0, 1);
      run_case("R5", "rising clock not chosen", 1, 1, 2'b01, 1, 4, 3, -2, NONE, 0, 0, 0, 0);
      run_case("R5", "rising clock hold side",  1, 1, 2'b01, 1, 4, 3, 1, NONE, 0, 0, 0, 0);
   endtask

   task automatic t_dat_mode();
      run_case("R6", "fall ignored in rise mode", 0, 1, 2'b01, 0, 4, 3, -1, NONE, 0, 0, 0, 0);
      run_case("R6", "fall counted in fall mode", 0, 1, 2'b10, 0, 4, 3, -1, NONE, 0, 0, 0, 1);
      run_case("R6", "rise ignored in fall mode", 0, 1, 2'b10, 1, 4, 3, 2, NONE, 0, 0, 0, 0);
      run_case("R6", "fall counted in both mode", 0, 1, 2'b11, 0, 4, 3, 2, NONE, 0, 0, 0, 1);
      run_case("R6", "none mode coincident",      0, 1, 2'b00, 1, 4, 3, 0, NONE, 0, 0, 0, 0);
   endtask

   task automatic t_qual();
      run_case("R7", "qualifier wrong level",   0, 1, 2'b01, 1, 4, 3, 0, NONE, 1, 1, 0, 0);
      run_case("R7", "qualifier right level",   0, 1, 2'b01, 1, 4, 3, 0, NONE, 1, 1, 1, 1);
      run_case("R7", "qualifier disabled",      0, 1, 2'b01, 1, 4, 3, 0, NONE, 0, 1, 0, 1);
      run_case("R7", "qualifier low required",  0, 1, 2'b01, 1, 4, 3, 2, NONE, 1, 0, 0, 1);
   endtask

   task automatic t_single();
      run_case("R8", "setup and hold same edge", 0, 1, 2'b11, 1, 4, 3, -1, 1, 0, 0, 0, 1);
      run_case("R8", "coincident then hold",     0, 1, 2'b11, 1, 4, 3, 0, 2, 0, 0, 0, 1);
   endtask

   initial begin
      t_reset();
      t_setup();
      t_hold();
      t_coincident();
      t_clk_pol();
      t_dat_mode();
      t_qual();
      t_single();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule